// File: doc/BRIEF.md
# Interrupt pending/enable CSR unit

This block holds the machine-level interrupt-pending and interrupt-enable state of a hart. It also presents two supervisor-level windows onto that same state. A single CSR access port picks one of four views with a 2-bit selector. Writes go through a per-view write mask into the shared storage. Reads return a masked, and for supervisor views delegation-filtered, image of that storage.

An interrupt controller drives strobed updates for the three machine-level pending bits (software, timer, external). Those updates bypass the software write mask and take priority over a same-cycle CSR write. A separate level input from the controller is ORed into the supervisor external pending bit on every read and in the activity outputs. A delegation mask input decides which machine-level bits the supervisor views can see and which of them a supervisor-enable write can change.

The unit exports, per privilege level, a 3-bit vector of effective pending AND enable, ordered {external, timer, software}. Trap logic downstream consumes these vectors.

Top module: `irq_csr_unit`

## Requirements
- R1: After reset both storage registers are zero, so all four views read zero while the external supervisor line is low.
- R2: Every view returns zero in all bits outside mask 0xBBB, including all bits above bit 11.
- R3: A write through view 0 (machine pending) changes only bits in mask 0x33B. Bits 11 and 7 keep their value and bit 3 is writable.
- R4: A write through view 2 (supervisor pending) changes only bits in mask 0x333 of the shared pending storage, and the change is visible in view 0.
- R5: A write through view 1 (machine enable) sets all bits in mask 0xBBB, and view 1 reads them back.
- R6: Bit 9 of views 0 and 2 reads as the stored bit ORed with the external supervisor pending input.
- R7: In views 2 and 3 each machine-level bit (11, 7, 3) reads as its stored value only when the same delegation bit is set, and reads zero otherwise. Bits in 0x333 are always visible.
- R8: A write through view 3 (supervisor enable) changes bits 11, 7 and 3 only where the delegation bit is set. Bits in 0x333 always pass through to the shared enable storage.
- R9: Hardware update strobe k with value v sets or clears pending bit 3 (k=0), 7 (k=1) or 11 (k=2) at the next clock edge, regardless of any write mask.
- R10: When a hardware update and a CSR write hit the same pending bit in one cycle, the hardware value is stored.
- R11: A CSR write takes effect at the clock edge that samples the strobe. The read data does not change before that edge and shows the new value after it.
- R12: The activity outputs for the machine, supervisor and user levels are the effective pending AND enable at bit positions {11,7,3}, {9,5,1} and {8,4,0}, output index 2/1/0 = external/timer/software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_view_i | input | 2 | View select: 0 machine pending, 1 machine enable, 2 supervisor pending, 3 supervisor enable |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for the selected view |
| hw_upd_i | input | 3 | Controller update strobes: 0 software, 1 timer, 2 external (machine level) |
| hw_val_i | input | 3 | Values written by the matching strobes |
| sext_pend_i | input | 1 | External supervisor pending line |
| deleg_i | input | XLEN | Delegation mask |
| m_act_o | output | 3 | Machine-level pending AND enable {ext, tim, sw} |
| s_act_o | output | 3 | Supervisor-level pending AND enable {ext, tim, sw} |
| u_act_o | output | 3 | User-level pending AND enable {ext, tim, sw} |

## Verification
The hardest situation to reach is the one where a controller strobe and a software write target the same machine software bit in the same cycle with opposite values. The CSR write mask allows that bit, so the only thing that decides the result is precedence. The bench drives both inputs at one falling edge, in both polarities, and then reads view 0. The supervisor windows get the same treatment: writes and reads through them are repeated under different delegation masks, and the effect is then read back through the unfiltered machine views.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int unsigned IW     = 12;
  localparam int unsigned NKIND  = 3;   // sw, tim, ext
  localparam int unsigned LVL_U  = 0;
  localparam int unsigned LVL_S  = 1;
  localparam int unsigned LVL_M  = 3;
  localparam int unsigned SEXT_BIT = 9;

  localparam logic [IW-1:0] RD_MASK   = 12'hBBB;
  localparam logic [IW-1:0] MIP_WMASK = 12'h33B;
  localparam logic [IW-1:0] SU_MASK   = 12'h333;
  localparam logic [IW-1:0] MLVL_MASK = 12'h888;

  typedef enum logic [1:0] {
    VIEW_MIP = 2'd0,
    VIEW_MIE = 2'd1,
    VIEW_SIP = 2'd2,
    VIEW_SIE = 2'd3
  } view_e;

  // bit position of interrupt kind k at level l
  function automatic int unsigned cause_bit(input int unsigned lvl, input int unsigned kind);
    return kind * 4 + lvl;
  endfunction
endpackage

// File: rtl/irq_wmask_gen.sv
module irq_wmask_gen
  import irq_csr_pkg::*;
(
  input  logic          we_i,
  input  logic [1:0]    view_i,
  input  logic [IW-1:0] deleg_i,
  output logic [IW-1:0] pend_wm_o,
  output logic [IW-1:0] en_wm_o
);
  always_comb begin
    pend_wm_o = '0;
    en_wm_o   = '0;
    if (we_i) begin
      case (view_e'(view_i))
        VIEW_MIP: pend_wm_o = MIP_WMASK;
        VIEW_SIP: pend_wm_o = SU_MASK;
        VIEW_MIE: en_wm_o   = RD_MASK;
        VIEW_SIE: en_wm_o   = SU_MASK | (deleg_i & MLVL_MASK);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_csr_pkg::*;
#(
  parameter int unsigned W = IW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_upd_i,
  input  logic [W-1:0] hw_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // hardware update has precedence over the software write
    assign d[b] = hw_upd_i[b] ? hw_val_i[b] :
                  wmask_i[b]  ? wdata_i[b]  : q_o[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_csr_pkg::*;
#(
  parameter int unsigned W = IW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~wmask_i) | (wdata_i & wmask_i);
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [1:0]      view_i,
  input  logic [IW-1:0]   pend_i,
  input  logic [IW-1:0]   en_i,
  input  logic [IW-1:0]   deleg_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [IW-1:0] sup_mask;
  logic [IW-1:0] rd;

  assign sup_mask = SU_MASK | (deleg_i & MLVL_MASK);

  always_comb begin
    case (view_e'(view_i))
      VIEW_MIP: rd = pend_i & RD_MASK;
      VIEW_MIE: rd = en_i & RD_MASK;
      VIEW_SIP: rd = pend_i & sup_mask;
      VIEW_SIE: rd = en_i & sup_mask;
      default:  rd = '0;
    endcase
  end

  assign rdata_o = {{(XLEN-IW){1'b0}}, rd};
endmodule

// File: rtl/irq_act_split.sv
module irq_act_split
  import irq_csr_pkg::*;
(
  input  logic [IW-1:0]    pend_i,
  input  logic [IW-1:0]    en_i,
  output logic [NKIND-1:0] m_act_o,
  output logic [NKIND-1:0] s_act_o,
  output logic [NKIND-1:0] u_act_o
);
  logic [IW-1:0] act;
  assign act = pend_i & en_i;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign m_act_o[k] = act[cause_bit(LVL_M, k)];
    assign s_act_o[k] = act[cause_bit(LVL_S, k)];
    assign u_act_o[k] = act[cause_bit(LVL_U, k)];
  end
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_view_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  input  logic [NKIND-1:0] hw_upd_i,
  input  logic [NKIND-1:0] hw_val_i,
  input  logic             sext_pend_i,
  input  logic [XLEN-1:0]  deleg_i,
  output logic [NKIND-1:0] m_act_o,
  output logic [NKIND-1:0] s_act_o,
  output logic [NKIND-1:0] u_act_o
);
  logic [IW-1:0] pend_q, en_q, pend_eff;
  logic [IW-1:0] pend_wm, en_wm;
  logic [IW-1:0] hw_upd_vec, hw_val_vec;
  logic [IW-1:0] deleg_lo, wdata_lo;
  logic          unused_hi;

  assign deleg_lo  = deleg_i[IW-1:0];
  assign wdata_lo  = csr_wdata_i[IW-1:0];
  assign unused_hi = ^{csr_wdata_i[XLEN-1:IW], deleg_i[XLEN-1:IW]};

  // spread controller strobes onto machine-level bit positions
  always_comb begin
    hw_upd_vec = '0;
    hw_val_vec = '0;
    for (int k = 0; k < NKIND; k++) begin
      hw_upd_vec[cause_bit(LVL_M, k)] = hw_upd_i[k];
      hw_val_vec[cause_bit(LVL_M, k)] = hw_val_i[k];
    end
  end

  irq_wmask_gen u_wmask (
    .we_i      (csr_we_i),
    .view_i    (csr_view_i),
    .deleg_i   (deleg_lo),
    .pend_wm_o (pend_wm),
    .en_wm_o   (en_wm)
  );

  irq_pend_reg #(.W(IW)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wmask_i  (pend_wm),
    .wdata_i  (wdata_lo),
    .hw_upd_i (hw_upd_vec),
    .hw_val_i (hw_val_vec),
    .q_o      (pend_q)
  );

  irq_en_reg #(.W(IW)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wmask_i (en_wm),
    .wdata_i (wdata_lo),
    .q_o     (en_q)
  );

  assign pend_eff = pend_q | (IW'(sext_pend_i) << SEXT_BIT);

  irq_rd_mux #(.XLEN(XLEN)) u_rd (
    .view_i  (csr_view_i),
    .pend_i  (pend_eff),
    .en_i    (en_q),
    .deleg_i (deleg_lo),
    .rdata_o (csr_rdata_o)
  );

  irq_act_split u_act (
    .pend_i  (pend_eff),
    .en_i    (en_q),
    .m_act_o (m_act_o),
    .s_act_o (s_act_o),
    .u_act_o (u_act_o)
  );
endmodule

// File: rtl/irq_csr_unit_chk.sv
module irq_csr_unit_chk
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_we_i,
  input logic [1:0]       csr_view_i,
  input logic [XLEN-1:0]  csr_wdata_i,
  input logic [XLEN-1:0]  csr_rdata_o,
  input logic [NKIND-1:0] hw_upd_i,
  input logic [NKIND-1:0] hw_val_i,
  input logic             sext_pend_i,
  input logic [XLEN-1:0]  deleg_i,
  input logic [IW-1:0]    pend_q,
  input logic [IW-1:0]    en_q,
  input logic [NKIND-1:0] s_act_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (pend_q == '0 && en_q == '0));

  assert_rd_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o & ~{{(XLEN-IW){1'b0}}, RD_MASK}) == '0);

  assert_mip_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_view_i == VIEW_MIP && !hw_upd_i[2] && !hw_upd_i[1])
    |=> (pend_q[11] == $past(pend_q[11]) && pend_q[7] == $past(pend_q[7])));

  assert_sext_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_view_i == VIEW_MIP && sext_pend_i) |-> csr_rdata_o[SEXT_BIT]);

  assert_sip_hide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_view_i == VIEW_SIP && !deleg_i[3]) |-> !csr_rdata_o[3]);

  assert_sie_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_view_i == VIEW_SIE && !deleg_i[11])
    |=> en_q[11] == $past(en_q[11]));

  assert_hw_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_upd_i[0] |=> pend_q[3] == $past(hw_val_i[0]));

  assert_mie_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_view_i == VIEW_MIE)
    |=> en_q == ($past(csr_wdata_i[IW-1:0]) & RD_MASK));

  assert_sext_act_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sext_pend_i && en_q[SEXT_BIT]) |-> s_act_o[2]);
endmodule

bind irq_csr_unit irq_csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_we_i    (csr_we_i),
  .csr_view_i  (csr_view_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .hw_upd_i    (hw_upd_i),
  .hw_val_i    (hw_val_i),
  .sext_pend_i (sext_pend_i),
  .deleg_i     (deleg_i),
  .pend_q      (pend_q),
  .en_q        (en_q),
  .s_act_o     (s_act_o)
);

// File: tb/irq_csr_unit_bench.sv
module irq_csr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int NV = 13;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            csr_we = 1'b0;
  logic [1:0]      csr_view = 2'd0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic [2:0]      hw_upd = '0;
  logic [2:0]      hw_val = '0;
  logic            sext = 1'b0;
  logic [XLEN-1:0] deleg = '0;
  logic [2:0]      m_act, s_act, u_act;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_csr_unit #(.XLEN(XLEN)) u_irq_csr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we), .csr_view_i(csr_view),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .hw_upd_i(hw_upd),
    .hw_val_i(hw_val), .sext_pend_i(sext), .deleg_i(deleg),
    .m_act_o(m_act), .s_act_o(s_act), .u_act_o(u_act)
  );

  // {req[4], we, view[2], wdata[12], deleg[12], sext, rview[2], exp[12]}
  localparam logic [45:0] VEC [NV] = '{
    {4'd3,  1'b1, 2'd0, 12'hFFF, 12'h000, 1'b0, 2'd0, 12'h33B}, // R3
    {4'd3,  1'b1, 2'd0, 12'h000, 12'h000, 1'b0, 2'd0, 12'h000}, // R3
    {4'd5,  1'b1, 2'd1, 12'hFFF, 12'h000, 1'b0, 2'd1, 12'hBBB}, // R5
    {4'd8,  1'b1, 2'd3, 12'h000, 12'h000, 1'b0, 2'd3, 12'h000}, // R8
    {4'd8,  1'b0, 2'd0, 12'h000, 12'h000, 1'b0, 2'd1, 12'h888}, // R8
    {4'd8,  1'b1, 2'd3, 12'hFFF, 12'h888, 1'b0, 2'd3, 12'hBBB}, // R8
    {4'd8,  1'b1, 2'd3, 12'h000, 12'h080, 1'b0, 2'd1, 12'h808}, // R8
    {4'd4,  1'b1, 2'd2, 12'hFFF, 12'h000, 1'b0, 2'd0, 12'h333}, // R4
    {4'd6,  1'b1, 2'd2, 12'h000, 12'h000, 1'b1, 2'd2, 12'h200}, // R6
    {4'd6,  1'b0, 2'd0, 12'h000, 12'h000, 1'b1, 2'd0, 12'h200}, // R6
    {4'd7,  1'b1, 2'd0, 12'h008, 12'h000, 1'b0, 2'd2, 12'h000}, // R7
    {4'd7,  1'b0, 2'd0, 12'h000, 12'h008, 1'b0, 2'd2, 12'h008}, // R7
    {4'd2,  1'b1, 2'd1, 12'h444, 12'h000, 1'b0, 2'd1, 12'h000}  // R2
  };

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] v, input string tag, input logic [11:0] exp);
    csr_view = v;
    #1;
    chk(tag, csr_rdata, {{(XLEN-12){1'b0}}, exp});
  endtask

  task automatic wr(input logic [1:0] v, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_view = v; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int v = 0; v < 4; v++) rd(2'(v), "R1 reset read", 12'h000);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 4; v++) rd(2'(v), "R1 after release", 12'h000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      csr_we    = VEC[i][41];
      csr_view  = VEC[i][40:39];
      csr_wdata = {{(XLEN-12){1'b0}}, VEC[i][38:27]};
      deleg     = {{(XLEN-12){1'b0}}, VEC[i][26:15]};
      sext      = VEC[i][14];
      @(negedge clk);
      csr_we = 1'b0;
      rd(VEC[i][13:12], $sformatf("R%0d vector %0d", VEC[i][45:42], i), VEC[i][11:0]);
    end
    deleg = '0; sext = 1'b0;

    // R2: upper write bits ignored, upper read bits zero
    wr(2'd0, {XLEN{1'b1}});
    rd(2'd0, "R2 upper bits", 12'h33B);

    // R9: controller sets machine external
    wr(2'd0, '0);
    @(negedge clk); hw_upd = 3'b100; hw_val = 3'b100;
    @(negedge clk); hw_upd = '0;
    rd(2'd0, "R9 hw set ext", 12'h800);

    // R10: collision, hardware 1 vs write 0 on bit 3
    @(negedge clk);
    csr_we = 1'b1; csr_view = 2'd0; csr_wdata = '0; hw_upd = 3'b001; hw_val = 3'b001;
    @(negedge clk); csr_we = 1'b0; hw_upd = '0;
    rd(2'd0, "R10 hw 1 wins", 12'h808);
    // R10: collision, hardware 0 vs write 1 on bit 3
    @(negedge clk);
    csr_we = 1'b1; csr_view = 2'd0; csr_wdata = 64'h8; hw_upd = 3'b001; hw_val = 3'b000;
    @(negedge clk); csr_we = 1'b0; hw_upd = '0;
    rd(2'd0, "R10 hw 0 wins", 12'h800);

    // R11: not visible before the edge, visible after
    @(negedge clk);
    csr_we = 1'b1; csr_view = 2'd1; csr_wdata = 64'hFFF;
    #1; chk("R11 before edge", csr_rdata, 64'h0);
    @(negedge clk); csr_we = 1'b0;
    rd(2'd1, "R11 after edge", 12'hBBB);

    // R12: activity vectors
    #1;
    chk("R12 m_act", {61'b0, m_act}, 64'h4);
    chk("R12 s_act idle", {61'b0, s_act}, 64'h0);
    sext = 1'b1; #1;
    chk("R12 s_act sext", {61'b0, s_act}, 64'h4);
    wr(2'd2, 64'h011);
    #1;
    chk("R12 u_act", {61'b0, u_act}, 64'h3);

    // R9: controller clears machine external
    sext = 1'b0;
    @(negedge clk); hw_upd = 3'b100; hw_val = 3'b000;
    @(negedge clk); hw_upd = '0;
    rd(2'd0, "R9 hw clear ext", 12'h011);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule